// File: doc/BRIEF.md
# Storage Mode and Reset Sequencer

This block sits behind a bus front end that has already decoded each register write into an address and a data byte, valid for one clock. It manages two things for a battery gauge: a low-power storage state and a guarded soft reset.

When the enable-low-power command arrives, the block arms a delay built from a prescaled tick. When the delay ends, it enters storage mode. In storage mode the low-power flag is set and the gauge-function enable is cleared. A rising edge on any of three monitored communication lines ends storage mode. The lines are the bus clock, the bus data and the single-wire line. Each line is first passed through a two-flop synchronizer. A rising edge seen while the delay is still running cancels the pending entry.

Separately, a detector watches for one exact run of three writes. When the run completes, the block emits a one-cycle reset request. Downstream logic uses this request to reload configuration registers. The same pulse also cancels a pending storage-mode entry.

Top module: `pwr_reset_seq`

## Requirements
- R1: After synchronous reset, `low_power` is 0, `gauge_en` is 1 and `reset_req` is 0.
- R2: A write of data 0x0B to address 0x0000 arms storage entry. `low_power` rises exactly TICK_DIV*ENTRY_TICKS clock edges after the edge that captured the write, and not earlier. With the defaults (TICK_DIV=32768 at 32.768 MHz, ENTRY_TICKS=6500) this is 6.5 s.
- R3: `gauge_en` is always the inverse of `low_power`, so gauging is disabled for the whole of storage mode.
- R4: In storage mode, a rising edge on `wake_in[0]` (bus clock), `wake_in[1]` (bus data) or `wake_in[2]` (single-wire line) clears `low_power` on the third rising clock edge after the input changes. A falling edge has no effect.
- R5: A rising edge on any wake line while entry is pending cancels the entry, and storage mode is not entered.
- R6: Three consecutive valid writes complete the unlock sequence: data 0x4F to 0xFF5A, then 0x7D to 0x0000, then 0x7D to 0x0080. The block then drives `reset_req` high for exactly one cycle, beginning at the clock edge that captures the third write.
- R7: A valid write that does not match the expected next step returns the detector to the start. If that write matches the first step, it counts as the first step.
- R8: A `reset_req` pulse cancels a pending storage-mode entry.
- R9: Cycles with `wr_valid` low leave the unlock progress unchanged, whatever `wr_addr` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Decoded register write present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wake_in | input | 3 | Asynchronous wake lines: [0] bus clock, [1] bus data, [2] single-wire |
| low_power | output | 1 | Storage mode active |
| gauge_en | output | 1 | Gauge functions enabled |
| reset_req | output | 1 | One-cycle reload request |

## Verification
The embedded assertions check the following on every cycle:
- the reset request is only ever one cycle wide, and it only follows a valid write at the final unlock step;
- idle cycles leave the unlock progress untouched;
- storage mode is only entered on the last tick of the delay;
- any wake edge or reset pulse seen while entry is pending, or a wake edge in storage, moves the state where it should.

Only the bench scenarios can show the following:
- the exact entry latency measured from the command;
- the three-edge wake latency for each line, and that falling edges are ignored;
- the restart rule when a broken sequence contains a fresh first step.

// File: rtl/pws_pkg.sv
// Package: shared types for the storage mode and reset sequencer.
// Holds the power state encoding and the width of the wake line group.
package pws_pkg;

    localparam int WAKE_LINES = 3;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_ARMED  = 2'd1,
        PM_STORE  = 2'd2
    } pm_state_t;

endpackage

// File: rtl/wake_edge_sync.sv
// wake_edge_sync: brings N asynchronous wake lines into the clock domain
// through two flops each, then flags a rising edge on any of them.
// Assumes the lines are level signals that stay stable for at least two
// clocks; shorter glitches may be missed.
module wake_edge_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_in,
    output logic         rise_any
);
    logic [N-1:0] rise_vec;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic s1, s2, s3;
        // Two-stage synchronizer plus a history flop for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= lines_in[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign rise_vec[g] = s2 & ~s3;
    end

    assign rise_any = |rise_vec;

endmodule

// File: rtl/unlock_detect.sv
// unlock_detect: tracks a fixed three-write address/data sequence and emits
// a registered one-cycle pulse when the third step matches. A mismatching
// valid write restarts the sequence, and counts as step one if it matches it.
// Assumes the step-one pattern differs from the later steps.
module unlock_detect #(
    parameter int               ADDR_W = 16,
    parameter int               DATA_W = 8,
    parameter logic [ADDR_W-1:0] S0_ADDR = 16'hFF5A,
    parameter logic [DATA_W-1:0] S0_DATA = 8'h4F,
    parameter logic [ADDR_W-1:0] S1_ADDR = 16'h0000,
    parameter logic [DATA_W-1:0] S1_DATA = 8'h7D,
    parameter logic [ADDR_W-1:0] S2_ADDR = 16'h0080,
    parameter logic [DATA_W-1:0] S2_DATA = 8'h7D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fire
);
    logic [1:0] step;
    logic       hit0, hit1, hit2;

    // Compare the current write against each step pattern.
    always_comb begin
        hit0 = (wr_addr == S0_ADDR) && (wr_data == S0_DATA);
        hit1 = (wr_addr == S1_ADDR) && (wr_data == S1_DATA);
        hit2 = (wr_addr == S2_ADDR) && (wr_data == S2_DATA);
    end

    // Advance, restart or complete the sequence on each valid write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= 2'd0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (wr_valid) begin
                unique case (step)
                    2'd0: step <= hit0 ? 2'd1 : 2'd0;
                    2'd1: step <= hit1 ? 2'd2 : (hit0 ? 2'd1 : 2'd0);
                    2'd2: begin
                        if (hit2) begin
                            fire <= 1'b1;
                            step <= 2'd0;
                        end else begin
                            step <= hit0 ? 2'd1 : 2'd0;
                        end
                    end
                    default: step <= 2'd0;
                endcase
            end
        end
    end

    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R6
    AST_FIRE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(wr_valid)); // R6
    AST_FIRE_FROM_LAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ($past(step) == 2'd2)); // R7
    AST_IDLE_HOLDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(step)); // R9

endmodule

// File: rtl/power_state_ctrl.sv
// power_state_ctrl: active / armed / storage state machine. A matching
// command arms a delay of TICK_DIV*ENTRY_TICKS clocks, after which storage
// mode is entered. A wake edge cancels arming or leaves storage. A soft
// reset pulse cancels arming only. Priority: soft reset, wake, command.
// Assumes TICK_DIV >= 2 and ENTRY_TICKS >= 1.
module power_state_ctrl
    import pws_pkg::*;
#(
    parameter int               ADDR_W      = 16,
    parameter int               DATA_W      = 8,
    parameter logic [ADDR_W-1:0] LP_ADDR    = 16'h0000,
    parameter logic [DATA_W-1:0] LP_DATA    = 8'h0B,
    parameter int               TICK_DIV    = 32768,
    parameter int               ENTRY_TICKS = 6500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake,
    input  logic              soft_rst,
    output logic              low_power,
    output logic              gauge_en
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int TW = $clog2(ENTRY_TICKS + 1);
    localparam logic [PW-1:0] PRE_LAST  = PW'(TICK_DIV - 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(ENTRY_TICKS - 1);

    pm_state_t    state;
    logic [PW-1:0] pre_cnt;
    logic [TW-1:0] tick_cnt;
    logic          lp_cmd;
    logic          tick;

    // Decode the enable-low-power command and the prescaler tick.
    always_comb begin
        lp_cmd = wr_valid && (wr_addr == LP_ADDR) && (wr_data == LP_DATA);
        tick   = (pre_cnt == PRE_LAST);
    end

    // State transitions and entry-delay counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PM_ACTIVE;
            pre_cnt  <= '0;
            tick_cnt <= '0;
        end else begin
            unique case (state)
                PM_ACTIVE: begin
                    if (lp_cmd && !soft_rst && !wake) begin
                        state    <= PM_ARMED;
                        pre_cnt  <= '0;
                        tick_cnt <= '0;
                    end
                end
                PM_ARMED: begin
                    if (soft_rst || wake) begin
                        state <= PM_ACTIVE;
                    end else if (lp_cmd) begin
                        pre_cnt  <= '0;
                        tick_cnt <= '0;
                    end else begin
                        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
                        if (tick) begin
                            if (tick_cnt == TICK_LAST) begin
                                state <= PM_STORE;
                            end
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                end
                PM_STORE: begin
                    if (wake) begin
                        state <= PM_ACTIVE;
                    end
                end
                default: state <= PM_ACTIVE;
            endcase
        end
    end

    assign low_power = (state == PM_STORE);
    assign gauge_en  = (state != PM_STORE);

    AST_ENTRY_ON_LAST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_power) |-> ($past(tick_cnt) == TICK_LAST)); // R2
    AST_STORE_NO_GAUGE: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |-> !gauge_en); // R3
    AST_WAKE_LEAVES_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && low_power) |=> !low_power); // R4
    AST_WAKE_CANCELS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && state == PM_ARMED) |=> (state == PM_ACTIVE)); // R5
    AST_SOFT_RST_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && state == PM_ARMED) |=> (state == PM_ACTIVE)); // R8

endmodule

// File: rtl/pwr_reset_seq.sv
// pwr_reset_seq: top of the storage mode and reset sequencer. Combines the
// wake-line synchronizer, the unlock sequence detector and the power state
// machine. Assumes writes arrive as single-cycle address/data strobes.
module pwr_reset_seq
    import pws_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int TICK_DIV    = 32768,
    parameter int ENTRY_TICKS = 6500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        wake_in,
    output logic              low_power,
    output logic              gauge_en,
    output logic              reset_req
);
    logic wake_rise;

    wake_edge_sync #(.N(WAKE_LINES)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (wake_in),
        .rise_any (wake_rise)
    );

    unlock_detect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .fire     (reset_req)
    );

    power_state_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .TICK_DIV    (TICK_DIV),
        .ENTRY_TICKS (ENTRY_TICKS)
    ) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wake      (wake_rise),
        .soft_rst  (reset_req),
        .low_power (low_power),
        .gauge_en  (gauge_en)
    );

endmodule

// File: tb/test_pwr_reset_seq.sv
module test_pwr_reset_seq;
    localparam int TD = 4;
    localparam int ET = 10;
    localparam int DELAY = TD * ET;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  wake_in = '0;
    logic        low_power, gauge_en, reset_req;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pwr_reset_seq #(.TICK_DIV(TD), .ENTRY_TICKS(ET)) i_pwr_reset_seq (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wake_in(wake_in), .low_power(low_power),
        .gauge_en(gauge_en), .reset_req(reset_req)
    );

    // {valid, addr, data, expected reset_req after that edge}
    localparam logic [25:0] VEC [22] = '{
        {1'b1, 16'hFF5A, 8'h4F, 1'b0},   // R6 full sequence
        {1'b1, 16'h0000, 8'h7D, 1'b0},
        {1'b1, 16'h0080, 8'h7D, 1'b1},
        {1'b1, 16'hFF5A, 8'h4F, 1'b0},   // R7 wrong data at step three
        {1'b1, 16'h0000, 8'h7D, 1'b0},
        {1'b1, 16'h0080, 8'h7C, 1'b0},
        {1'b1, 16'h0000, 8'h7D, 1'b0},
        {1'b1, 16'h0080, 8'h7D, 1'b0},
        {1'b1, 16'hFF5A, 8'h4F, 1'b0},   // R7 repeated first step
        {1'b1, 16'hFF5A, 8'h4F, 1'b0},
        {1'b1, 16'h0000, 8'h7D, 1'b0},
        {1'b1, 16'h0080, 8'h7D, 1'b1},
        {1'b1, 16'hFF5A, 8'h4F, 1'b0},   // R9 idle cycles in between
        {1'b0, 16'h0080, 8'h7D, 1'b0},
        {1'b1, 16'h0000, 8'h7D, 1'b0},
        {1'b0, 16'h1234, 8'h00, 1'b0},
        {1'b1, 16'h0080, 8'h7D, 1'b1},
        {1'b1, 16'hFF5A, 8'h4F, 1'b0},   // R7 repeated second step
        {1'b1, 16'h0000, 8'h7D, 1'b0},
        {1'b1, 16'h0000, 8'h7D, 1'b0},
        {1'b1, 16'h0080, 8'h7D, 1'b0},
        {1'b0, 16'h0000, 8'h00, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic enter_store();
        wr(16'h0000, 8'h0B);
        repeat (DELAY) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 low_power", low_power, 0);
        chk("R1 gauge_en", gauge_en, 1);
        chk("R1 reset_req", reset_req, 0);

        // Vector table for the unlock detector
        for (int i = 0; i < 22; i++) begin
            @(negedge clk);
            wr_valid = VEC[i][25]; wr_addr = VEC[i][24:9]; wr_data = VEC[i][8:1];
            @(posedge clk); #1;
            chk($sformatf("R6/R7/R9 vec %0d reset_req", i), reset_req, VEC[i][0]);
            chk("R3 idle during table", low_power, 0);
        end
        @(negedge clk); wr_valid = 1'b0;
        @(posedge clk); #1;
        chk("R6 single-cycle pulse", reset_req, 0);

        // R2 exact entry latency
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 16'h0000; wr_data = 8'h0B;
        @(posedge clk); #1;
        @(negedge clk); wr_valid = 1'b0;
        repeat (DELAY - 1) @(posedge clk);
        #1;
        chk("R2 not yet in storage", low_power, 0);
        @(posedge clk); #1;
        chk("R2 entered storage", low_power, 1);
        chk("R3 gauge disabled", gauge_en, 0);

        // R4 wake on line 0 with exact latency
        @(negedge clk); wake_in[0] = 1'b1;
        repeat (2) @(posedge clk); #1;
        chk("R4 still stored at 2 edges", low_power, 1);
        @(posedge clk); #1;
        chk("R4 bus clock wake", low_power, 0);
        chk("R3 gauge re-enabled", gauge_en, 1);

        // R4 falling edge ignored, then line 1 and line 2 wake
        enter_store();
        chk("R4 stored with line high", low_power, 1);
        @(negedge clk); wake_in[0] = 1'b0;
        repeat (6) @(posedge clk); #1;
        chk("R4 falling edge ignored", low_power, 1);
        @(negedge clk); wake_in[1] = 1'b1;
        repeat (4) @(posedge clk); #1;
        chk("R4 bus data wake", low_power, 0);
        @(negedge clk); wake_in[1] = 1'b0;
        enter_store();
        chk("R2 re-entry", low_power, 1);
        @(negedge clk); wake_in[2] = 1'b1;
        repeat (4) @(posedge clk); #1;
        chk("R4 single-wire wake", low_power, 0);
        @(negedge clk); wake_in[2] = 1'b0;
        repeat (4) @(posedge clk);

        // R5 wake edge during the delay cancels entry
        wr(16'h0000, 8'h0B);
        repeat (10) @(posedge clk);
        @(negedge clk); wake_in[1] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); wake_in[1] = 1'b0;
        repeat (DELAY + 10) @(posedge clk); #1;
        chk("R5 pending entry cancelled", low_power, 0);

        // R8 reset pulse cancels pending entry
        wr(16'h0000, 8'h0B);
        wr(16'hFF5A, 8'h4F);
        wr(16'h0000, 8'h7D);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 16'h0080; wr_data = 8'h7D;
        @(posedge clk); #1;
        chk("R8 reset_req pulse", reset_req, 1);
        @(negedge clk); wr_valid = 1'b0;
        repeat (DELAY + 10) @(posedge clk); #1;
        chk("R8 entry cancelled by reset", low_power, 0);
        chk("R1 gauge stays enabled", gauge_en, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule